// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands of `OPW` bits over several clock cycles and returns a signed product of `2*OPW` bits. It uses one combined shift register. The top section holds the running partial product. The bottom section starts out holding the multiplier. One guard bit sits below the bottom section.

In each working cycle the lowest multiplier bit and the guard bit below it are read as a pair. The pair chooses whether the multiplicand is subtracted from the top section, added to it, or left alone. The whole register then shifts right by one place and copies its sign bit into the vacated top position. After `OPW` such cycles the top section is the high word of the product and the bottom section is the low word.

A caller raises `start` for one cycle while the block is idle, with both operands present. It then waits for the one-cycle `done` pulse. The product stays on the outputs until the next operation is accepted.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy_o` and `done_o` are 0 and `prod_hi_o` and `prod_lo_o` are all zeros.
- R2: A `start_i` sampled high at a rising edge while `busy_o` is 0 is accepted. `busy_o` is 1 after that edge.
- R3: Take a start accepted with multiplicand `a` and multiplier `b`. In the `done_o` cycle, `{prod_hi_o, prod_lo_o}` equals the two's-complement product `a*b` as a `2*OPW`-bit value. `prod_hi_o` is bits `2*OPW-1` down to `OPW`.
- R4: Take a start accepted at edge k. `busy_o` stays 1 through edge k+OPW and is 0 after it. `done_o` is 1 for exactly the one cycle after edge k+OPW, and it is never 1 together with `busy_o`.
- R5: A `start_i` raised while `busy_o` is 1 is ignored. The running operation's result and timing are unchanged, and the new operands are never multiplied.
- R6: The most negative operand value `-2^(OPW-1)` gives the correct product whether it is the multiplicand, the multiplier, or both. For OPW=8, (-128)*(-128) = 0x4000.
- R7: While idle with no start, `{prod_hi_o, prod_lo_o}` holds its last value.
- R8: A start raised in the `done_o` cycle is accepted at the next edge, with no idle cycle between operations.
- R9: A zero multiplicand or a zero multiplier gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a multiplication |
| mcand_i | input | OPW | Signed multiplicand |
| mplier_i | input | OPW | Signed multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| prod_hi_o | output | OPW | Upper half of the signed product |
| prod_lo_o | output | OPW | Lower half of the signed product |

## Verification
The end of one multiplication and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start_i` in the very cycle `done_o` is seen. It then judges two things: the finishing product is still shown during that cycle, and the new operation begins with no idle gap.

The second collision is a start request arriving while the register is shifting. The bench fires a request with different operands in the middle of a run. It judges the finishing product and the `done_o` cycle against those of the original operands.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

   typedef enum logic [1:0] {
      BOP_NONE = 2'd0,
      BOP_ADD  = 2'd1,
      BOP_SUB  = 2'd2
   } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_mul_pkg::*;
(
   input  logic      cur_bit,
   input  logic      right_bit,
   output booth_op_e op
);

   // A falling edge into a run of ones subtracts; leaving the run adds.
   always_comb begin
      unique case ({cur_bit, right_bit})
         2'b10:   op = BOP_SUB;
         2'b01:   op = BOP_ADD;
         default: op = BOP_NONE;
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_mul_pkg::*;
#(
   parameter int W     = 9,
   parameter int STYLE = 0
) (
   input  logic [W-1:0] acc,
   input  logic [W-1:0] addend,
   input  booth_op_e    op,
   output logic [W-1:0] sum
);

   generate
      if (STYLE == 0) begin : g_direct
         always_comb begin
            unique case (op)
               BOP_ADD: sum = acc + addend;
               BOP_SUB: sum = acc - addend;
               default: sum = acc;
            endcase
         end
      end else begin : g_single_adder
         logic [W-1:0] opnd;
         logic         cin;
         always_comb begin
            unique case (op)
               BOP_ADD: begin opnd = addend;    cin = 1'b0; end
               BOP_SUB: begin opnd = ~addend;   cin = 1'b1; end
               default: begin opnd = '0;        cin = 1'b0; end
            endcase
            sum = acc + opnd + {{(W-1){1'b0}}, cin};
         end
      end
   endgenerate

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int ITER  = 8,
   parameter int CNT_W = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            if (cnt_q == LAST) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

   assign load = start && !busy_q;
   assign step = busy_q;
   assign busy = busy_q;
   assign done = done_q;

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_mul_pkg::*;
#(
   parameter int OPW       = 8,
   parameter int ADD_STYLE = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [OPW-1:0] mcand_i,
   input  logic [OPW-1:0] mplier_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [OPW-1:0] prod_hi_o,
   output logic [OPW-1:0] prod_lo_o
);

   localparam int ACC_W = OPW + 1;
   localparam int CNT_W = (OPW > 2) ? $clog2(OPW) : 1;

   generate
      if (OPW < 2) begin : g_bad_width
         $error("booth_seq_mul: OPW must be at least 2");
      end
      if (ADD_STYLE != 0 && ADD_STYLE != 1) begin : g_bad_style
         $error("booth_seq_mul: ADD_STYLE must be 0 or 1");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [OPW-1:0]   low_q;
   logic             guard_q;
   logic [OPW-1:0]   mcand_q;

   logic             load;
   logic             step;
   booth_op_e        op;
   logic [ACC_W-1:0] sum;

   booth_seq_ctrl #(
      .ITER  (OPW),
      .CNT_W (CNT_W)
   ) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start_i),
      .load  (load),
      .step  (step),
      .busy  (busy_o),
      .done  (done_o)
   );

   booth_recode u_recode (
      .cur_bit   (low_q[0]),
      .right_bit (guard_q),
      .op        (op)
   );

   booth_addsub #(
      .W     (ACC_W),
      .STYLE (ADD_STYLE)
   ) u_addsub (
      .acc    (acc_q),
      .addend ({mcand_q[OPW-1], mcand_q}),
      .op     (op),
      .sum    (sum)
   );

   // Combined register {acc, low, guard}, shifted right with the sign kept.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q   <= '0;
         low_q   <= '0;
         guard_q <= 1'b0;
         mcand_q <= '0;
      end else if (load) begin
         acc_q   <= '0;
         low_q   <= mplier_i;
         guard_q <= 1'b0;
         mcand_q <= mcand_i;
      end else if (step) begin
         acc_q   <= {sum[ACC_W-1], sum[ACC_W-1:1]};
         low_q   <= {sum[0], low_q[OPW-1:1]};
         guard_q <= low_q[0];
      end
   end

   assign prod_hi_o = acc_q[OPW-1:0];
   assign prod_lo_o = low_q;

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
   parameter int OPW = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start_i,
   input logic [OPW-1:0] mcand_i,
   input logic [OPW-1:0] mplier_i,
   input logic           busy_o,
   input logic           done_o,
   input logic [OPW-1:0] prod_hi_o,
   input logic [OPW-1:0] prod_lo_o
);

   localparam int RUN_W = $clog2(OPW + 1) + 1;

   logic [RUN_W-1:0]   run_len;
   logic [OPW-1:0]     cap_a;
   logic [OPW-1:0]     cap_b;
   logic [2*OPW-1:0]   cap_prod;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         cap_a   <= '0;
         cap_b   <= '0;
      end else begin
         run_len <= busy_o ? run_len + 1'b1 : '0;
         if (start_i && !busy_o) begin
            cap_a <= mcand_i;
            cap_b <= mplier_i;
         end
      end
   end

   assign cap_prod = $signed({{OPW{cap_a[OPW-1]}}, cap_a}) *
                     $signed({{OPW{cap_b[OPW-1]}}, cap_b});

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R4
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R4
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R4 R5
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (run_len == RUN_W'(OPW)));

   // R3 R5 R6
   product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ({prod_hi_o, prod_lo_o} == cap_prod));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable({prod_hi_o, prod_lo_o}));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.OPW(OPW)) u_chk (.*);

// File: tb/booth_seq_mul_test.sv
module booth_seq_mul_test;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [N-1:0] mcand_i = '0;
   logic [N-1:0] mplier_i = '0;
   logic         busy_o, done_o;
   logic [N-1:0] prod_hi_o, prod_lo_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string tag_in = "R3";

   always #2 clk = ~clk;

   booth_seq_mul #(.OPW(N)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mcand_i   (mcand_i),
      .mplier_i  (mplier_i),
      .busy_o    (busy_o),
      .done_o    (done_o),
      .prod_hi_o (prod_hi_o),
      .prod_lo_o (prod_lo_o)
   );

   // Behavioural reference state
   bit           m_busy = 0;
   bit           m_done = 0;
   bit           m_have = 0;
   int           m_cnt = 0;
   logic [2*N-1:0] m_prod = '0;
   logic [2*N-1:0] m_res = '0;
   string        m_tag = "R3";

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_have = 0; m_cnt = 0; m_res = '0;
      end else begin
         m_done = 0;
         if (m_busy) begin
            if (start_i) m_tag = "R5";
            m_cnt++;
            if (m_cnt == N) begin
               m_busy = 0;
               m_done = 1;
               m_res  = m_prod;
               m_have = 1;
            end
         end else if (start_i) begin
            longint pa, pb, pp;
            pa = longint'($signed(mcand_i));
            pb = longint'($signed(mplier_i));
            pp = pa * pb;
            m_prod = pp[2*N-1:0];
            m_busy = 1;
            m_cnt  = 0;
            m_tag  = tag_in;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(busy_o == m_busy, "R2 R4", "busy", longint'(busy_o), longint'(m_busy));
         chk(done_o == m_done, "R4", "done", longint'(done_o), longint'(m_done));
         if (m_done)
            chk({prod_hi_o, prod_lo_o} == m_res, m_tag, "product",
                longint'({prod_hi_o, prod_lo_o}), longint'(m_res));
         else if (!m_busy && m_have)
            chk({prod_hi_o, prod_lo_o} == m_res, "R7", "held product",
                longint'({prod_hi_o, prod_lo_o}), longint'(m_res));
      end
   end

   task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
      @(negedge clk);
      start_i = 1'b1; mcand_i = a; mplier_i = b; tag_in = tag;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      while (!done_o) @(negedge clk);
   endtask

   task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input string tag);
      issue(a, b, tag);
      wait_done();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy_o == 0 && done_o == 0, "R1", "flags in reset",
          longint'({busy_o, done_o}), 0);
      chk({prod_hi_o, prod_lo_o} == 0, "R1", "product in reset",
          longint'({prod_hi_o, prod_lo_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && {prod_hi_o, prod_lo_o} == 0, "R1",
          "state after release", longint'({busy_o, done_o, prod_hi_o, prod_lo_o}), 0);

      run(8'd2, 8'd7, "R3");
      run(8'd2, 8'hFD, "R3");
      run(8'd127, 8'd127, "R3");
      run(8'hFF, 8'hFF, "R3");
      run(8'h80, 8'h80, "R6");
      run(8'h80, 8'd127, "R6");
      run(8'd127, 8'h80, "R6");
      run(8'h80, 8'hFF, "R6");
      run(8'd0, 8'h93, "R9");
      run(8'h5A, 8'd0, "R9");

      // R7: idle gap with operands wiggling but no start
      mcand_i = 8'h11; mplier_i = 8'h22;
      repeat (4) @(negedge clk);

      // R5: start during busy must be ignored
      issue(8'd5, 8'hF9, "R5");
      @(negedge clk);
      start_i = 1'b1; mcand_i = 8'h7F; mplier_i = 8'h7F;
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
      @(negedge clk);

      // R8: start in the done cycle
      issue(8'h33, 8'hC4, "R3");
      wait_done();
      start_i = 1'b1; mcand_i = 8'h80; mplier_i = 8'h01; tag_in = "R8";
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o == 1, "R8", "busy after back-to-back start", longint'(busy_o), 1);
      wait_done();
      @(negedge clk);

      for (int i = 0; i < 300; i++) begin
         run(N'($urandom), N'($urandom), "R3");
      end

      repeat (3) @(negedge clk);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule